// File: doc/BRIEF.md
# Zone-Configured External Bus Sequencer

This block turns single read and write requests from a small processor core into timed cycles on an external memory and I/O bus. The upper address bits select one of four zones: three memory zones and, in the highest zone, the I/O space. Each zone has its own configuration word. That word sets the number of wait states, the number of hold cycles after the strobe, whether a read may finish in a single clock, and two idle-insertion controls that keep bus drivers apart when traffic moves from one zone to another.

The core raises a valid signal with the address, direction and write data, and keeps them steady until the block answers with a one-clock ready pulse. On a read, the captured data is presented with that pulse. Configuration words come in as one flat vector that holds one word per zone, and each word is sampled when its access is accepted. The package supplies a default word per zone for integrations that do not tune the timing.

Top module: `zone_bus_seq`

## Requirements
- R1: While reset is asserted and right after it, the read strobe, write strobe, data-bus enable and ready outputs are all low.
- R2: The zone is the top two address bits. In each 16-bit zone word, bits [2:0] are the wait count, bits [4:3] are the hold count, bit 9 enables an idle after leaving the zone, bit 10 enables an idle before entering it, and bit 11 enables fast reads.
- R3: A write holds the write strobe high for 1 + wait clocks. The data bus is driven with the write data and the address is held throughout.
- R4: A normal read holds the read strobe high for 2 + wait clocks, leaves the data bus undriven, and captures read data in its last strobe clock.
- R5: A read in a zone with the fast bit set and a wait count of zero strobes for exactly one clock. With a non-zero wait count, the fast bit has no effect and the read takes 2 + wait clocks.
- R6: After the strobe, the hold count gives that many clocks with both strobes low and the address held. For a write, data is still driven during these clocks.
- R7: If the zone of the previous access has bit 9 set and the new access targets another zone, exactly one idle clock comes between acceptance and the strobe.
- R8: If the new access's zone has bit 10 set and differs from the previous access's zone, exactly one idle clock is inserted before its strobe.
- R9: When both idle controls apply, only one idle clock is inserted. No idle is inserted when the zone is unchanged, or for the first access after reset.
- R10: During an idle clock, both strobes are low and the data bus is not driven. The two strobes are never high together.
- R11: Ready is high for exactly one clock per request, in the clock after the last strobe or hold clock. Read data is valid on respRdata in that clock.
- R12: The package default word sets only bit 9, and only for zone 0 and the I/O zone. With all defaults, an idle appears only when leaving zone 0 or the I/O zone for another zone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request valid, held until respReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address, top ZONE_W bits select the zone |
| reqWdata | input | DATA_W | Write data |
| zoneCfg | input | NUM_ZONES*16 | Concatenated per-zone configuration words, zone 0 in the low word |
| respReady | output | 1 | One-clock completion pulse |
| respRdata | output | DATA_W | Captured read data |
| busAddr | output | ADDR_W | External address |
| busWdata | output | DATA_W | External write data |
| busDataOe | output | 1 | External data bus driven by this block |
| busRd | output | 1 | Read strobe, active high |
| busWr | output | 1 | Write strobe, active high |
| busRdata | input | DATA_W | External read data |

## Verification
The main function is driven with one sequence of accesses that walks every zone under a mixed configuration. Each step is picked so that one idle rule decides the result: leaving a zone with the post-idle bit, entering a zone with the pre-idle bit, both rules at once, neither rule across a zone change, and repeated accesses within one zone. Reads are run with fast mode under zero and non-zero wait counts, and with hold cycles. During those hold cycles the external data shows a wrong value, so the check can tell whether data is captured at the strobe or later. Directed runs then cover the first access after reset and the default configuration.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Per-zone configuration word layout
  localparam int CFG_W     = 16;
  localparam int WAIT_LSB  = 0;
  localparam int WAIT_W    = 3;
  localparam int HOLD_LSB  = 3;
  localparam int HOLD_W    = 2;
  localparam int POST_BIT  = 9;   // idle after leaving this zone
  localparam int PRE_BIT   = 10;  // idle before entering this zone
  localparam int FAST_BIT  = 11;  // single-clock read when wait is zero

  // Longest strobe: normal read, 2 + max wait, counted down to zero
  localparam int STB_MAX   = (1 << WAIT_W) + 1;
  localparam int STB_CNT_W = $clog2(STB_MAX + 1);

  typedef logic [CFG_W-1:0] zoneCfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } bsqState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic driveRd;
    logic driveWr;
    logic driveData;
  } bsqStrobes_t;

  // Default word: post-idle only on zone 0 and the I/O (top) zone (R12)
  function automatic zoneCfg_t defaultZoneCfg(input int zone, input int numZones);
    zoneCfg_t c;
    c = '0;
    if (zone == 0 || zone == numZones - 1) c[POST_BIT] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int ZONE_W = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic                             reqWrite,
  input  logic [ZONE_W-1:0]                reqZone,
  input  logic [(1<<ZONE_W)*CFG_W-1:0]     zoneCfg,
  output logic                             respReady,
  output bsqStrobes_t                      stb
);

  localparam int NUM_ZONES = 1 << ZONE_W;

  bsqState_t             state;
  logic [STB_CNT_W-1:0]  stbCnt;
  logic [HOLD_W-1:0]     holdCnt;
  logic                  curWrite;
  logic [ZONE_W-1:0]     lastZone;
  logic                  haveLast;

  zoneCfg_t cfgArr [NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_cfg
    assign cfgArr[z] = zoneCfg[z*CFG_W +: CFG_W];
  end

  zoneCfg_t             newCfg;
  zoneCfg_t             lastCfg;
  logic [WAIT_W-1:0]    newWait;
  logic [HOLD_W-1:0]    newHold;
  logic                 fastOk;
  logic                 gapNeed;
  logic [STB_CNT_W-1:0] newStbCnt;

  assign newCfg  = cfgArr[reqZone];
  assign lastCfg = cfgArr[lastZone];
  assign newWait = newCfg[WAIT_LSB +: WAIT_W];
  assign newHold = newCfg[HOLD_LSB +: HOLD_W];

  // R5: fast read only counts when the wait field is zero
  assign fastOk = newCfg[FAST_BIT] && (newWait == '0);

  // R7/R8/R9: one idle on a zone change if either side asks for it
  assign gapNeed = haveLast && (reqZone != lastZone) &&
                   (lastCfg[POST_BIT] || newCfg[PRE_BIT]);

  // Strobe counter loads length-1: write 1+wait, fast read 1, normal read 2+wait
  always_comb begin
    if (reqWrite || fastOk) newStbCnt = STB_CNT_W'(newWait);
    else                    newStbCnt = STB_CNT_W'(newWait) + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stbCnt   <= '0;
      holdCnt  <= '0;
      curWrite <= 1'b0;
      lastZone <= '0;
      haveLast <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            stbCnt   <= newStbCnt;
            holdCnt  <= newHold;
            curWrite <= reqWrite;
            lastZone <= reqZone;
            haveLast <= 1'b1;
            state    <= gapNeed ? ST_GAP : ST_STROBE;
          end
        end
        ST_GAP:    state <= ST_STROBE;
        ST_STROBE: begin
          if (stbCnt == '0) state  <= (holdCnt != '0) ? ST_HOLD : ST_DONE;
          else              stbCnt <= stbCnt - 1'b1;
        end
        ST_HOLD: begin
          if (holdCnt == HOLD_W'(1)) state   <= ST_DONE;
          else                       holdCnt <= holdCnt - 1'b1;
        end
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.latchReq  = (state == ST_IDLE) && reqValid;
    stb.driveRd   = (state == ST_STROBE) && !curWrite;
    stb.driveWr   = (state == ST_STROBE) && curWrite;
    stb.capture   = (state == ST_STROBE) && !curWrite && (stbCnt == '0);
    stb.driveData = curWrite && ((state == ST_STROBE) || (state == ST_HOLD));
  end

  // R11: completion pulse in the clock after the last bus clock
  assign respReady = (state == ST_DONE);

endmodule

// File: rtl/bsq_datapath.sv
module bsq_datapath
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsqStrobes_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] respRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busDataOe,
  output logic              busRd,
  output logic              busWr
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (stb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      // R4: sample external data in the last strobe clock
      if (stb.capture) rdataQ <= busRdata;
    end
  end

  assign busAddr   = addrQ;
  assign busWdata  = wdataQ;
  assign busDataOe = stb.driveData;
  assign busRd     = stb.driveRd;
  assign busWr     = stb.driveWr;
  assign respRdata = rdataQ;

endmodule

// File: rtl/zone_bus_seq.sv
module zone_bus_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ZONE_W = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  input  logic [(1<<ZONE_W)*CFG_W-1:0] zoneCfg,
  output logic                         respReady,
  output logic [DATA_W-1:0]            respRdata,
  output logic [ADDR_W-1:0]            busAddr,
  output logic [DATA_W-1:0]            busWdata,
  output logic                         busDataOe,
  output logic                         busRd,
  output logic                         busWr,
  input  logic [DATA_W-1:0]            busRdata
);

  bsqStrobes_t      stb;
  logic [ZONE_W-1:0] reqZone;

  // R2: zone from the top address bits
  assign reqZone = reqAddr[ADDR_W-1 -: ZONE_W];

  bsq_ctrl #(.ZONE_W(ZONE_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqZone   (reqZone),
    .zoneCfg   (zoneCfg),
    .respReady (respReady),
    .stb       (stb)
  );

  bsq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busRdata  (busRdata),
    .respRdata (respRdata),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busDataOe (busDataOe),
    .busRd     (busRd),
    .busWr     (busWr)
  );

endmodule

// File: rtl/zone_bus_seq_chk.sv
module zone_bus_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              respReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDataOe,
  input logic              busRd,
  input logic              busWr
);

  logic busActive;
  assign busActive = busRd || busWr || busDataOe;

  // R10: strobes never overlap
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R11: ready is a single-clock pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    respReady |=> !respReady);

  // R4: no drive while reading
  p_read_undriven_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !busDataOe);

  // R3: write strobe always comes with driven data
  p_write_driven_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> busDataOe);

  // R6: address steady across consecutive active bus clocks
  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && $past(busActive)) |-> $stable(busAddr));

  // R11: ready never overlaps an active bus clock
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> !busActive);

endmodule

bind zone_bus_seq zone_bus_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .respReady (respReady),
  .busAddr   (busAddr),
  .busDataOe (busDataOe),
  .busRd     (busRd),
  .busWr     (busWr)
);

// File: tb/zone_bus_seq_tb_top.sv
module zone_bus_seq_tb_top;
  import bsq_pkg::*;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int ZONE_W = 2;
  localparam int NZ     = 1 << ZONE_W;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [NZ*CFG_W-1:0] zoneCfg = '0;
  logic respReady;
  logic [DATA_W-1:0] respRdata;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata;
  logic busDataOe, busRd, busWr;
  logic [DATA_W-1:0] busRdata;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // External memory model: valid data only while the read strobe is high
  always_comb busRdata = busRd ? (busAddr[7:0] ^ 8'h5A) : 8'hEE;

  zone_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZONE_W(ZONE_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .zoneCfg(zoneCfg),
    .respReady(respReady), .respRdata(respRdata), .busAddr(busAddr),
    .busWdata(busWdata), .busDataOe(busDataOe), .busRd(busRd),
    .busWr(busWr), .busRdata(busRdata)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [1:0]  gap;
    logic [3:0]  stb;
    logic [2:0]  hold;
  } vec_t;

  // Config: z0 post; z1 wait2 hold1 pre; z2 fast hold2; z3 wait1 post pre fast
  localparam logic [NZ*CFG_W-1:0] MIX_CFG = {16'h0E01, 16'h0810, 16'h040A, 16'h0200};

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0012, 8'h00, 2'd0, 4'd2, 3'd0},  // first access, normal read
    '{1'b1, 16'h0034, 8'hA5, 2'd0, 4'd1, 3'd0},  // same zone, post set, no idle
    '{1'b0, 16'h8001, 8'h00, 2'd1, 4'd1, 3'd2},  // leave z0 (post); fast read, hold 2
    '{1'b0, 16'h8002, 8'h00, 2'd0, 4'd1, 3'd2},  // same zone
    '{1'b1, 16'h4003, 8'h3C, 2'd1, 4'd3, 3'd1},  // enter z1 (pre); write wait 2
    '{1'b0, 16'h4004, 8'h00, 2'd0, 4'd4, 3'd1},  // read wait 2 -> 4
    '{1'b0, 16'hC005, 8'h00, 2'd1, 4'd3, 3'd0},  // enter z3 (pre); fast ignored, wait 1
    '{1'b1, 16'hC006, 8'h69, 2'd0, 4'd2, 3'd0},  // write wait 1
    '{1'b0, 16'h0007, 8'h00, 2'd1, 4'd2, 3'd0},  // leave z3 (post)
    '{1'b1, 16'hC008, 8'h96, 2'd1, 4'd2, 3'd0},  // post and pre both: one idle
    '{1'b1, 16'h8009, 8'h0F, 2'd1, 4'd1, 3'd2},  // leave z3 (post); write hold 2
    '{1'b0, 16'h400A, 8'h00, 2'd1, 4'd4, 3'd1},  // enter z1 (pre)
    '{1'b0, 16'h000B, 8'h00, 2'd0, 4'd2, 3'd0}   // zone change, neither rule
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runAccess(input logic wr, input logic [15:0] addr,
                           input logic [7:0] wd, input int expGap,
                           input int expStb, input int expHold);
    int pre = 0, stbN = 0, post = 0, cyc = 0;
    bit seen = 1'b0, done = 1'b0, badStb = 1'b0, badHold = 1'b0, badGap = 1'b0;
    logic [7:0] rd;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (respReady) begin
        done = 1'b1;
        rd = respRdata;
      end else if (busRd || busWr) begin
        seen = 1'b1;
        stbN++;
        if (busAddr != addr) badStb = 1'b1;
        if (busRd && busWr) badStb = 1'b1;
        if (wr && !(busWr && busDataOe && busWdata == wd)) badStb = 1'b1;
        if (!wr && !(busRd && !busDataOe)) badStb = 1'b1;
      end else if (!seen) begin
        pre++;
        if (busDataOe) badGap = 1'b1;
      end else begin
        post++;
        if (busAddr != addr || busDataOe != wr || (wr && busWdata != wd)) badHold = 1'b1;
      end
    end
    reqValid = 1'b0;
    chk(done, "R11", "ready seen", int'(done), 1);
    chk(pre == expGap, "R7 R8 R9", "idle clocks", pre, expGap);
    chk(!badGap, "R10", "idle clock quiet", int'(badGap), 0);
    if (wr) chk(stbN == expStb, "R3", "write strobe clocks", stbN, expStb);
    else    chk(stbN == expStb, "R4 R5", "read strobe clocks", stbN, expStb);
    chk(!badStb, "R3 R4", "strobe phase signals", int'(badStb), 0);
    chk(post == expHold, "R6", "hold clocks", post, expHold);
    chk(!badHold, "R6", "hold phase signals", int'(badHold), 0);
    if (!wr) chk(rd == (addr[7:0] ^ 8'h5A), "R4 R11", "read data", int'(rd),
                 int'(addr[7:0] ^ 8'h5A));
    @(negedge clk);
    chk(!respReady, "R11", "ready single clock", int'(respReady), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busRd && !busWr && !busDataOe && !respReady, "R1", "outputs in reset",
        int'({busRd, busWr, busDataOe, respReady}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busRd && !busWr && !busDataOe && !respReady, "R1", "outputs after reset",
        int'({busRd, busWr, busDataOe, respReady}), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    zoneCfg = MIX_CFG;
    doReset();

    // Table walk, R2 zone decode and field layout exercised by MIX_CFG
    for (int i = 0; i < NV; i++) begin
      runAccess(VECS[i].wr, VECS[i].addr, VECS[i].wd,
                int'(VECS[i].gap), int'(VECS[i].stb), int'(VECS[i].hold));
    end

    // R9: first access after reset into a pre-idle zone has no idle
    doReset();
    runAccess(1'b0, 16'hC0F0, 8'h00, 0, 3, 0);

    // R12: default configuration
    for (int z = 0; z < NZ; z++) zoneCfg[z*CFG_W +: CFG_W] = defaultZoneCfg(z, NZ);
    chk(zoneCfg[1*CFG_W +: CFG_W] == '0 && zoneCfg[0 +: CFG_W] == 16'h0200 &&
        zoneCfg[3*CFG_W +: CFG_W] == 16'h0200, "R12", "default words",
        int'(zoneCfg[15:0]), 16'h0200);
    doReset();
    runAccess(1'b0, 16'h0010, 8'h00, 0, 2, 0);  // first
    runAccess(1'b0, 16'h4010, 8'h00, 1, 2, 0);  // R12 leave z0
    runAccess(1'b1, 16'h8010, 8'h77, 0, 1, 0);  // R12 z1 -> z2 none
    runAccess(1'b0, 16'hC010, 8'h00, 0, 2, 0);  // R12 enter I/O none
    runAccess(1'b0, 16'h0020, 8'h00, 1, 2, 0);  // R12 leave I/O

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule